// File: doc/BRIEF.md
# Analog Test Bus Interface Controller

This block is the digital control section of a mixed-signal boundary-scan test bus interface. A four-bit control word is shifted in serially through the data scan path, least significant bit first. The word is then moved into a holding register on the update strobe. The holding register and the active instruction class together choose one of ten switch patterns. The chosen pattern is presented as a registered, strictly one-hot vector of ten switch enables. Those enables connect, isolate, drive or clamp two internal analog buses and two external analog test pins.

Pattern 0 isolates both external pins and clamps both internal buses. Pattern 1 joins the second pin to the second bus, pattern 2 joins the first pin to the first bus, and pattern 3 joins both pairs for measurement. Patterns 4 to 7 force the two external pins to the constant pairs 00, 01, 10 and 11 for interconnect testing. Patterns 8 and 9 are reserved for characterization.

A two-state hold machine governs the output. In `ST_LIVE` the switch register follows the decoded pattern. In `ST_FROZEN`, which is entered whenever the CLAMP class is present, both the holding register and the switch register keep their values. The transition `LIVE_TO_FROZEN` fires on the CLAMP class, `FROZEN_TO_LIVE` fires on any other class, and each state otherwise stays where it is.

Top module: `atb_ctrl`

## Requirements
- R1: An asynchronous low level on `trst_n` clears the holding register and the scan stage to zero and forces `sw_en` to `10'b0000000001`, which is pattern 0.
- R2: With `shift_en` high and `capture_en` low, each rising `tck` edge shifts `scan_in` into bit 3 of the scan stage while the stage moves toward bit 0; `scan_out` always shows bit 0. With `capture_en` high, the stage loads the holding register. Capture has priority over shift.
- R3: The holding register changes only on a rising edge with `update_en` high. Capturing and shifting alone never alter `sw_en`.
- R4: `sw_en` is registered and always has exactly one bit set, where bit k means pattern Pk. It takes the pattern of a new holding-register value on the second rising edge after the update strobe.
- R5: Under class EXTEST (3) or RUNBIST (4), control words 0 to 7 select patterns P0 to P7.
- R6: Under EXTEST or RUNBIST, word 9 selects P8 and word 10 selects P9; word 8 and words 11 to 15 select P0.
- R7: Under class PROBE (6) or INTEST (7), words 0 to 3 select P0 to P3, and every higher word selects P0.
- R8: Under class BYPASS/IDCODE/USERCODE (0), SAMPLE/PRELOAD (1) or HIGHZ (2), the pattern is P0 for every control word.
- R9: While class CLAMP (5) is present, `sw_en` holds its value and update strobes are ignored. After leaving CLAMP, the output still reflects the word held before CLAMP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_en | input | 1 | Capture strobe: load the scan stage from the holding register |
| shift_en | input | 1 | Shift strobe: serial shift, LSB first |
| update_en | input | 1 | Update strobe: move the scan stage into the holding register |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out (scan stage bit 0) |
| instr_class | input | 3 | Decoded instruction class, with codes as in R5 to R9 |
| sw_en | output | 10 | One-hot switch pattern enables, bit k = Pk |

## Verification
The checker watches several properties on every cycle. These are: the one-hot shape of `sw_en`, the P0 value at reset release, the serial shift direction, holding-register stability without an update strobe, the CLAMP freeze of both registers, and P0 under the passive classes. The full decode table can only be shown by the bench's scenarios, which sweep every non-CLAMP class against all sixteen control words. The bench scenarios also cover the serial read-back order after capture and the two-edge latency. They also show that a word loaded during CLAMP never reaches the output once CLAMP ends.

// File: rtl/atb_pkg.sv
package atb_pkg;

    localparam int CW_W    = 4;
    localparam int NPAT    = 10;
    localparam int PIDX_W  = $clog2(NPAT);
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_BYPASS  = 3'd0,
        CLS_SAMPLE  = 3'd1,
        CLS_HIGHZ   = 3'd2,
        CLS_EXTEST  = 3'd3,
        CLS_RUNBIST = 3'd4,
        CLS_CLAMP   = 3'd5,
        CLS_PROBE   = 3'd6,
        CLS_INTEST  = 3'd7
    } icls_e;

    typedef enum logic {
        ST_LIVE   = 1'b0,
        ST_FROZEN = 1'b1
    } hold_e;

    // Pattern index chosen by class and control word.
    function automatic logic [PIDX_W-1:0] pick_pattern(icls_e cls, logic [CW_W-1:0] word);
        logic [PIDX_W-1:0] idx;
        idx = '0;
        unique case (cls)
            CLS_EXTEST, CLS_RUNBIST, CLS_CLAMP: begin
                if (!word[3])            idx = PIDX_W'(word[2:0]);
                else if (word == 4'd9)   idx = PIDX_W'(8);
                else if (word == 4'd10)  idx = PIDX_W'(9);
                else                     idx = '0;
            end
            CLS_PROBE, CLS_INTEST: begin
                if (word[3:2] == 2'b00)  idx = PIDX_W'(word[1:0]);
                else                     idx = '0;
            end
            CLS_BYPASS, CLS_SAMPLE, CLS_HIGHZ: idx = '0;
            default:                           idx = '0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/atb_scan_stage.sv
module atb_scan_stage #(
    parameter int W = 4
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic         scan_in,
    input  logic [W-1:0] held_word,
    output logic [W-1:0] stage,
    output logic         scan_out
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stage <= '0;
        end else if (capture_en) begin
            stage <= held_word;
        end else if (shift_en) begin
            stage <= {scan_in, stage[W-1:1]};
        end
    end

    assign scan_out = stage[0];

endmodule

// File: rtl/atb_update_reg.sv
module atb_update_reg #(
    parameter int W = 4
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/atb_pattern_decode.sv
module atb_pattern_decode
    import atb_pkg::*;
#(
    parameter int N = NPAT
) (
    input  icls_e            cls,
    input  logic [CW_W-1:0]  word,
    output logic [N-1:0]     onehot
);

    logic [PIDX_W-1:0] idx;

    assign idx = pick_pattern(cls, word);

    for (genvar g = 0; g < N; g++) begin : g_pat
        assign onehot[g] = (idx == PIDX_W'(g));
    end

endmodule

// File: rtl/atb_ctrl.sv
module atb_ctrl
    import atb_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic [CLS_W-1:0]  instr_class,
    output logic [NPAT-1:0]   sw_en
);

    localparam logic [NPAT-1:0] P0_VEC = NPAT'(1);

    icls_e             cls;
    hold_e             st_q;
    hold_e             st_nxt;
    logic [CW_W-1:0]   stage_q;
    logic [CW_W-1:0]   word_q;
    logic [NPAT-1:0]   pat_dec;
    logic              upd_load;

    assign cls = icls_e'(instr_class);

    // Hold machine: next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_LIVE:   if (cls == CLS_CLAMP) st_nxt = ST_FROZEN;
            ST_FROZEN: if (cls != CLS_CLAMP) st_nxt = ST_LIVE;
            default:   st_nxt = ST_LIVE;
        endcase
    end

    // Hold machine: state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= ST_LIVE;
        else         st_q <= st_nxt;
    end

    assign upd_load = update_en && (st_nxt == ST_LIVE);

    atb_scan_stage #(.W(CW_W)) u_stage (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .scan_in    (scan_in),
        .held_word  (word_q),
        .stage      (stage_q),
        .scan_out   (scan_out)
    );

    atb_update_reg #(.W(CW_W)) u_upd (
        .tck    (tck),
        .trst_n (trst_n),
        .load   (upd_load),
        .d      (stage_q),
        .q      (word_q)
    );

    atb_pattern_decode #(.N(NPAT)) u_dec (
        .cls    (cls),
        .word   (word_q),
        .onehot (pat_dec)
    );

    // Hold machine: output register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sw_en <= P0_VEC;
        end else begin
            unique case (st_nxt)
                ST_LIVE:   sw_en <= pat_dec;
                ST_FROZEN: sw_en <= sw_en;
                default:   sw_en <= P0_VEC;
            endcase
        end
    end

endmodule

// File: rtl/atb_ctrl_chk.sv
module atb_ctrl_chk
    import atb_pkg::*;
(
    input logic              tck,
    input logic              trst_n,
    input logic              capture_en,
    input logic              shift_en,
    input logic              update_en,
    input logic              scan_in,
    input logic [CLS_W-1:0]  instr_class,
    input logic [CW_W-1:0]   stage,
    input logic [CW_W-1:0]   word,
    input logic [NPAT-1:0]   sw_en
);

    assert_reset_p0_R1: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(trst_n) |-> (sw_en == NPAT'(1)));

    assert_shift_msb_in_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> (stage[CW_W-1] == $past(scan_in)));

    assert_word_hold_R3: assert property (@(posedge tck) disable iff (!trst_n)
        !update_en |=> $stable(word));

    assert_onehot_R4: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(sw_en) == 1);

    assert_passive_p0_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_class == CLS_BYPASS || instr_class == CLS_SAMPLE || instr_class == CLS_HIGHZ)
        |=> (sw_en == NPAT'(1)));

    assert_clamp_freeze_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_class == CLS_CLAMP) |=> ($stable(sw_en) && $stable(word)));

endmodule

bind atb_ctrl atb_ctrl_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .capture_en  (capture_en),
    .shift_en    (shift_en),
    .update_en   (update_en),
    .scan_in     (scan_in),
    .instr_class (instr_class),
    .stage       (stage_q),
    .word        (word_q),
    .sw_en       (sw_en)
);

// File: tb/atb_ctrl_bench.sv
module atb_ctrl_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       capture_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       update_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [2:0] instr_class = 3'd0;
    logic       scan_out;
    logic [9:0] sw_en;

    atb_ctrl u_atb_ctrl (
        .tck         (tck),
        .trst_n      (trst_n),
        .capture_en  (capture_en),
        .shift_en    (shift_en),
        .update_en   (update_en),
        .scan_in     (scan_in),
        .scan_out    (scan_out),
        .instr_class (instr_class),
        .sw_en       (sw_en)
    );

    always #5 tck = ~tck;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];
    event       ev_sample;

    // Reference decode written from the requirements
    function automatic logic [9:0] ref_pattern(logic [2:0] c, logic [3:0] w);
        int p;
        p = 0;
        if (c == 3'd3 || c == 3'd4) begin          // R5 / R6
            if (w < 4'd8)        p = int'(w);
            else if (w == 4'd9)  p = 8;
            else if (w == 4'd10) p = 9;
        end else if (c == 3'd6 || c == 3'd7) begin // R7
            if (w < 4'd4)        p = int'(w);
        end                                        // R8: P0
        return 10'd1 << p;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares against the output
    initial begin
        forever begin
            @(ev_sample);
            while (exp_q.size() > 0) begin
                check(tag_q.pop_front(), 32'(sw_en), 32'(exp_q.pop_front()));
            end
        end
    end

    // Driver helpers
    task automatic load_word(logic [3:0] w);
        for (int i = 0; i < 4; i++) begin
            @(negedge tck);
            shift_en = 1'b1;
            scan_in  = w[i];
        end
        @(negedge tck);
        shift_en  = 1'b0;
        update_en = 1'b1;
        @(negedge tck);
        update_en = 1'b0;
    endtask

    task automatic expect_sw(string tag, logic [9:0] exp);
        @(negedge tck);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> ev_sample;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge tck);
        check("R1 sw_en in reset", 32'(sw_en), 32'h1);
        check("R1 scan_out in reset", 32'(scan_out), 32'h0);
        trst_n = 1'b1;
        expect_sw("R1 after release", 10'h001);

        // R5 R6 R7 R8: sweep every non-clamp class against all words
        for (int c = 0; c < 8; c++) begin
            if (c == 5) continue;
            @(negedge tck);
            instr_class = 3'(c);
            for (int w = 0; w < 16; w++) begin
                load_word(4'(w));
                expect_sw($sformatf("R5_R6_R7_R8 cls=%0d word=%0d", c, w),
                          ref_pattern(3'(c), 4'(w)));
            end
        end

        // R4: latency - old pattern one edge after update, new on the second
        @(negedge tck);
        instr_class = 3'd3;
        load_word(4'd2);
        expect_sw("R4 setup P2", 10'h004);
        for (int i = 0; i < 4; i++) begin
            @(negedge tck);
            shift_en = 1'b1;
            scan_in  = 1'(4'd6 >> i);
        end
        @(negedge tck);
        shift_en  = 1'b0;
        update_en = 1'b1;
        @(negedge tck);
        update_en = 1'b0;
        check("R4 one edge after update", 32'(sw_en), 32'h004);
        @(negedge tck);
        check("R4 second edge after update", 32'(sw_en), 32'h040);

        // R2 / R3: capture then serial read-back, LSB first
        load_word(4'hB);
        expect_sw("R3 setup word 11 -> P0", 10'h001);
        load_word(4'd9);
        expect_sw("R6 setup word 9 -> P8", 10'h100);
        @(negedge tck);
        capture_en = 1'b1;
        @(negedge tck);
        capture_en = 1'b0;
        shift_en   = 1'b1;
        scan_in    = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check($sformatf("R2 scan_out bit %0d", i), 32'(scan_out), 32'((4'd9 >> i) & 4'd1));
            @(negedge tck);
        end
        shift_en = 1'b0;
        check("R3 shift without update keeps sw_en", 32'(sw_en), 32'h100);
        repeat (2) @(negedge tck);
        check("R3 still unchanged", 32'(sw_en), 32'h100);

        // R9: clamp freezes output and ignores updates
        load_word(4'd5);
        expect_sw("R5 setup P5", 10'h020);
        @(negedge tck);
        instr_class = 3'd5;
        load_word(4'd10);
        expect_sw("R9 frozen during clamp", 10'h020);
        @(negedge tck);
        instr_class = 3'd6;
        load_word(4'd1);
        expect_sw("R7 probe word 1 -> P1", 10'h002);
        @(negedge tck);
        instr_class = 3'd5;
        load_word(4'd3);
        expect_sw("R9 clamp holds P1", 10'h002);
        @(negedge tck);
        instr_class = 3'd3;
        expect_sw("R9 old word 1 after clamp", 10'h002);
        load_word(4'd10);
        expect_sw("R6 word 10 -> P9 after clamp", 10'h200);

        // R1: asynchronous reset mid-run
        @(negedge tck);
        trst_n = 1'b0;
        #1;
        check("R1 async reset sw_en", 32'(sw_en), 32'h1);
        @(negedge tck);
        trst_n = 1'b1;
        expect_sw("R1 word cleared -> P0", 10'h001);
        load_word(4'd7);
        expect_sw("R5 word 7 -> P7", 10'h080);

        repeat (2) @(negedge tck);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule